// File: doc/BRIEF.md
# Remote Terminal Address Latch

This block holds the 5-bit terminal address of a serial-bus remote terminal, together with one odd-parity bit. It can take the address from external address and parity pins, or from a value that software writes. A latch-control input picks one of three ways to capture it. Held low, the output follows the selected source. A low-to-high transition captures one value. Held high, a capture happens only when software writes the trigger register, and only after that trigger has been armed through two other configuration registers.

The held address is checked for odd parity. A command-address comparator reports whether an incoming command is for this terminal. A broadcast address (all ones) is always accepted. A non-broadcast match is accepted only when parity is valid. The protocol engine presents command addresses on `cmd_addr_i` and uses `cmd_hit_o` to decide whether to respond.

Top module: `rta_latch_unit`

## Requirements
- R1: While `rst_ni` is low, the held address is 0 and the held parity is 1, so `par_ok_o` is 1. The source select, the enhanced bit and the trigger enable are all cleared, and the software shadow value is {address 0, parity 1}.
- R2: Bit 5 of register 6 selects the source. 0 selects the pins `pin_addr_i`/`pin_par_i`. 1 selects the software shadow value, and the pins then have no effect on the outputs. Every write to register 5 loads the shadow: address from data bits 5..1, parity from data bit 0.
- R3: `par_ok_o` is 1 exactly when the five address bits plus the parity bit contain an odd number of ones.
- R4: For a non-broadcast `cmd_addr_i`, `cmd_hit_o` is 1 only when it equals `term_addr_o` and `par_ok_o` is 1.
- R5: `cmd_addr_i` equal to 31 always gives `cmd_hit_o` = 1, whatever the parity.
- R6: While the synchronized latch control is low, the outputs take the selected source value at each clock edge, one cycle after it is presented.
- R7: `latch_ctl_i` passes through a two-flop synchronizer. On the first edge at which the synchronized level is high and was low one edge earlier, the selected source is captured. It is then held until the level drops or a trigger write occurs.
- R8: While the synchronized level is high, a write to register 5 captures a new value if register 3 bit 15 and register 4 bit 3 are both 1. With the software source, data bits 5..1 give the address and data bit 0 gives the parity.
- R9: In the same trigger case with the pin source, the data bits are ignored and the pins are sampled at the write edge.
- R10: While the level is high with no rising edge, the held value does not change: pin changes, other writes, and register 5 writes without both enables leave it as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register number |
| wr_data_i | input | 16 | Register write data |
| pin_addr_i | input | 5 | External terminal address |
| pin_par_i | input | 1 | External address parity |
| latch_ctl_i | input | 1 | Latch control, asynchronous |
| cmd_addr_i | input | 5 | Address field of a received command |
| term_addr_o | output | 5 | Held terminal address |
| term_par_o | output | 1 | Held parity bit |
| par_ok_o | output | 1 | Odd parity valid |
| cmd_hit_o | output | 1 | Command is accepted by this terminal |

## Verification
Register writes, pin values and transparent-mode loads reach `term_addr_o`/`term_par_o` one clock edge after they are presented. A change on `latch_ctl_i` changes the capture behaviour only on the third edge, because the synchronizer adds two stages and the edge detector adds a third. `par_ok_o` and `cmd_hit_o` are combinational on the held value and on `cmd_addr_i`. The bench drives inputs at the falling edge and updates a reference model at each rising edge with this same stage count. It compares all four outputs at the following falling edge, so every check sees a fully settled result for that edge.

// File: rtl/rta_pkg.sv
package rta_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned REGSEL_W = 3;

  localparam logic [REGSEL_W-1:0] REG_ENH = 3'd3;
  localparam logic [REGSEL_W-1:0] REG_LEN = 3'd4;
  localparam logic [REGSEL_W-1:0] REG_TRG = 3'd5;
  localparam logic [REGSEL_W-1:0] REG_SRC = 3'd6;

  localparam int unsigned ENH_BIT = 15;
  localparam int unsigned LEN_BIT = 3;
  localparam int unsigned SRC_BIT = 5;

  typedef struct packed {
    logic enh;
    logic lat_en;
    logic src_sw;
  } rta_cfg_t;
endpackage

// File: rtl/rta_sync.sv
module rta_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign lvl_o  = sh_q[LAST];
  assign rise_o = sh_q[LAST] & ~sh_q[STAGES];

  // R7: a synchronized level rise must come from the previous stage
  p_sync_chain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lvl_o) |-> $past(sh_q[LAST-1]));
endmodule

// File: rtl/rta_cfg.sv
module rta_cfg
  import rta_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned RW = REGSEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [RW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output rta_cfg_t      cfg_o,
  output logic [AW:0]   shadow_o,
  output logic          trg_o,
  output logic [AW:0]   trg_val_o
);
  localparam logic [AW:0] RST_VAL = {{AW{1'b0}}, 1'b1};

  rta_cfg_t    cfg_q;
  logic [AW:0] shadow_q;
  logic        wr_enh, wr_len, wr_src, wr_trg;

  assign wr_enh = wr_en_i && (wr_addr_i == REG_ENH);
  assign wr_len = wr_en_i && (wr_addr_i == REG_LEN);
  assign wr_src = wr_en_i && (wr_addr_i == REG_SRC);
  assign wr_trg = wr_en_i && (wr_addr_i == REG_TRG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      shadow_q <= RST_VAL;
    end else begin
      if (wr_enh) cfg_q.enh    <= wr_data_i[ENH_BIT];
      if (wr_len) cfg_q.lat_en <= wr_data_i[LEN_BIT];
      if (wr_src) cfg_q.src_sw <= wr_data_i[SRC_BIT];
      if (wr_trg) shadow_q     <= wr_data_i[AW:0];
    end
  end

  assign cfg_o     = cfg_q;
  assign shadow_o  = shadow_q;
  assign trg_o     = wr_trg && cfg_q.enh && cfg_q.lat_en;
  assign trg_val_o = wr_data_i[AW:0];

  p_src_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_src |=> cfg_o.src_sw == $past(wr_data_i[SRC_BIT]));
  p_trg_armed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trg_o |-> (cfg_o.enh && cfg_o.lat_en));
endmodule

// File: rtl/rta_capture.sv
module rta_capture #(
  parameter int unsigned AW = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        src_sw_i,
  input  logic [AW:0] shadow_i,
  input  logic [AW:0] pins_i,
  input  logic        lvl_i,
  input  logic        rise_i,
  input  logic        trg_i,
  input  logic [AW:0] trg_val_i,
  output logic [AW:0] held_o
);
  localparam logic [AW:0] RST_VAL = {{AW{1'b0}}, 1'b1};

  logic [AW:0] src, held_q, held_d;

  assign src = src_sw_i ? shadow_i : pins_i;

  always_comb begin
    held_d = held_q;
    if (!lvl_i || rise_i) held_d = src;
    else if (trg_i)       held_d = src_sw_i ? trg_val_i : pins_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= RST_VAL;
    else         held_q <= held_d;
  end

  assign held_o = held_q;

  p_transparent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_i |=> held_o == $past(src));
  p_edge_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> held_o == $past(src));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i && !rise_i && !trg_i) |=> $stable(held_o));
endmodule

// File: rtl/rta_latch_unit.sv
module rta_latch_unit
  import rta_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [REGSEL_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   pin_addr_i,
  input  logic                pin_par_i,
  input  logic                latch_ctl_i,
  input  logic [ADDR_W-1:0]   cmd_addr_i,
  output logic [ADDR_W-1:0]   term_addr_o,
  output logic                term_par_o,
  output logic                par_ok_o,
  output logic                cmd_hit_o
);
  localparam logic [ADDR_W-1:0] BCAST = {ADDR_W{1'b1}};

  rta_cfg_t          cfg;
  logic [ADDR_W:0]   shadow, trg_val, held;
  logic              trg, lvl, rise;

  rta_sync #(.STAGES(2)) i_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(latch_ctl_i),
    .lvl_o (lvl),   .rise_o(rise)
  );

  rta_cfg i_cfg (
    .clk_i    (clk_i),     .rst_ni  (rst_ni),
    .wr_en_i  (wr_en_i),   .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .cfg_o    (cfg),       .shadow_o(shadow),
    .trg_o    (trg),       .trg_val_o(trg_val)
  );

  rta_capture #(.AW(ADDR_W)) i_cap (
    .clk_i    (clk_i),      .rst_ni  (rst_ni),
    .src_sw_i (cfg.src_sw), .shadow_i(shadow),
    .pins_i   ({pin_addr_i, pin_par_i}),
    .lvl_i    (lvl),        .rise_i  (rise),
    .trg_i    (trg),        .trg_val_i(trg_val),
    .held_o   (held)
  );

  assign term_addr_o = held[ADDR_W:1];
  assign term_par_o  = held[0];
  assign par_ok_o    = ^held;
  assign cmd_hit_o   = (cmd_addr_i == BCAST) || (par_ok_o && (cmd_addr_i == term_addr_o));

  p_bcast_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_addr_i == BCAST) |-> cmd_hit_o);
  p_bad_par_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_ok_o && cmd_addr_i != BCAST) |-> !cmd_hit_o);
endmodule

// File: tb/test_rta_latch_unit.sv
module test_rta_latch_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [4:0]  pin_addr_i = '0;
  logic        pin_par_i = 1'b0;
  logic        latch_ctl_i = 1'b0;
  logic [4:0]  cmd_addr_i = '0;
  logic [4:0]  term_addr_o;
  logic        term_par_o, par_ok_o, cmd_hit_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  rta_latch_unit i_rta_latch_unit (.*);

  // reference model
  logic       m_s1, m_s2, m_s3, m_enh, m_len, m_sw;
  logic [5:0] m_held, m_shadow;
  string      m_tag;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_enh = 0; m_len = 0; m_sw = 0;
      m_held = 6'b000001; m_shadow = 6'b000001; m_tag = "R1";
    end else begin
      logic rise, lvl, wr5;
      logic [5:0] src;
      rise = m_s2 && !m_s3;
      lvl  = m_s2;
      src  = m_sw ? m_shadow : {pin_addr_i, pin_par_i};
      wr5  = wr_en_i && wr_addr_i == 3'd5;
      if (!lvl) begin
        m_held = src; m_tag = m_sw ? "R2" : "R6";
      end else if (rise) begin
        m_held = src; m_tag = "R7";
      end else if (wr5 && m_enh && m_len) begin
        m_held = m_sw ? wr_data_i[5:0] : {pin_addr_i, pin_par_i};
        m_tag  = m_sw ? "R8" : "R9";
      end else m_tag = "R10";
      if (wr_en_i && wr_addr_i == 3'd3) m_enh = wr_data_i[15];
      if (wr_en_i && wr_addr_i == 3'd4) m_len = wr_data_i[3];
      if (wr_en_i && wr_addr_i == 3'd6) m_sw  = wr_data_i[5];
      if (wr5) m_shadow = wr_data_i[5:0];
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = latch_ctl_i;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic ok, hit;
    ok  = ^m_held;
    hit = (cmd_addr_i == 5'd31) || (ok && cmd_addr_i == m_held[5:1]);
    chk({m_tag, " addr"}, term_addr_o, m_held[5:1]);
    chk({m_tag, " par"}, term_par_o, m_held[0]);
    chk("R3 par_ok", par_ok_o, ok);
    chk(cmd_addr_i == 5'd31 ? "R5 hit" : "R4 hit", cmd_hit_o, hit);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i); check_all();
    wr_en_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk_i); check_all(); end
  endtask

  initial begin
    #200000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1553));
    @(negedge clk_i); @(negedge clk_i);
    // R1 reset state
    chk("R1 addr", term_addr_o, 0);
    chk("R1 par", term_par_o, 1);
    chk("R1 par_ok", par_ok_o, 1);
    rst_ni = 1;
    // R6 transparent from pins, bad parity (R3, R4)
    pin_addr_i = 5'h0A; pin_par_i = 0; cmd_addr_i = 5'h0A;
    idle(2);
    cmd_addr_i = 5'd31; idle(1);                  // R5 broadcast with bad parity
    pin_par_i = 1; cmd_addr_i = 5'h0A; idle(2);   // R4 valid match
    // R7 rising edge capture, then pins ignored (R10)
    latch_ctl_i = 1; idle(4);
    pin_addr_i = 5'h15; pin_par_i = 0; idle(3);
    // R10 trigger write without enables
    wr(3'd5, 16'h0007); idle(1);
    // R9 armed trigger with pin source
    wr(3'd3, 16'h8000); wr(3'd4, 16'h0008);
    wr(3'd5, 16'hFFFF); idle(1);
    // R8 software source trigger
    wr(3'd6, 16'h0020);
    wr(3'd5, 16'h0027); idle(2);
    // R2 software transparent, pins ignored
    latch_ctl_i = 0; idle(4);
    pin_addr_i = 5'h1F; pin_par_i = 1; idle(2);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(15) == 0) latch_ctl_i = ~latch_ctl_i;
      if ($urandom_range(3) == 0) begin
        pin_addr_i = 5'($urandom); pin_par_i = 1'($urandom);
      end
      case ($urandom_range(3))
        0: cmd_addr_i = 5'd31;
        1: cmd_addr_i = term_addr_o;
        default: cmd_addr_i = 5'($urandom);
      endcase
      wr_en_i = ($urandom_range(3) == 0);
      wr_addr_i = ($urandom_range(3) == 0) ? 3'($urandom) : 3'($urandom_range(6, 3));
      wr_data_i = 16'($urandom);
      @(negedge clk_i); check_all();
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule